// File: doc/BRIEF.md
# Lockstep Wave Divergence Mask Unit

This unit tracks which of the 64 lanes of a lockstep vector wave are active while the wave runs through structured if / else / endif control flow. Instead of giving each lane its own program counter, the sequencer presents a branch operation and, for an IF, the per-lane result of the branch condition. The unit narrows, flips or restores the active-lane mask to match.

Before narrowing the mask, an IF pushes the enclosing mask onto an internal last-in first-out store. ELSE takes the lanes that were active at the IF and removes the ones that ran the first arm. ENDIF pops the stored mask back. After an IF or ELSE, a skip indication tells the sequencer that no lane is left to run the following arm, so it can jump over that arm.

The nesting level is held by a small state machine with three states:
- NEST_EMPTY: no saved masks.
- NEST_PARTIAL: between one and DEPTH-1 saved masks.
- NEST_FULL: DEPTH saved masks.

It has these transitions:
- push_first: EMPTY to PARTIAL.
- push_inner: stays in PARTIAL.
- push_last: PARTIAL to FULL.
- pop_from_full: FULL to PARTIAL.
- pop_inner: stays in PARTIAL.
- pop_last: PARTIAL to EMPTY.
- hold: no change, when an operation neither pushes nor pops or is rejected.

An operation that would overflow or underflow the store is rejected and latches a sticky error.

Top module: `divmask_ctrl`

## Requirements
- R1: After reset the active mask is all ones, skip and error are low, and no masks are saved.
- R2: Operation code 1 (IF), accepted when fewer than 8 masks are saved, pushes the current mask. In the next cycle the mask equals the condition mask ANDed with the previous mask.
- R3: Skip is high in the cycle after an accepted IF exactly when the new mask is all zeros.
- R4: Operation code 2 (ELSE), accepted when at least one mask is saved, sets the mask to the most recently saved mask ANDed with the inverse of the current mask. The saved masks are left unchanged.
- R5: Skip is high in the cycle after an accepted ELSE exactly when the resulting mask is all zeros.
- R6: Operation code 3 (ENDIF), accepted when at least one mask is saved, restores the most recently saved mask and removes it from the store.
- R7: Operation code 0 (none) leaves the mask unchanged. Skip is low in the following cycle, and after any operation other than an accepted IF or ELSE.
- R8: Up to 8 levels nest, and ENDIFs restore the saved masks in reverse order of saving.
- R9: An IF while 8 masks are saved raises error and leaves the mask and the saved masks unchanged.
- R10: An ELSE or ENDIF while no mask is saved raises error and leaves the mask unchanged.
- R11: Error stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | Branch operation: 0 none, 1 IF, 2 ELSE, 3 ENDIF |
| cmp_mask | input | 64 | Per-lane branch condition, used by IF |
| exec_mask | output | 64 | Active-lane mask, valid the cycle after the operation |
| skip | output | 1 | The arm that follows has no active lane |
| err | output | 1 | Sticky nesting overflow or underflow flag |

## Verification
The condition mask is driven with several patterns, each of which separates a different fault:
- All ones checks that IF keeps the enclosing lanes.
- All zeros checks that skip is raised.
- Alternating lanes and the two edge lanes expose a wrong bit order or an OR used in place of AND.
- Sparse pseudo-random words expose a wrong inversion in ELSE.

A full 8-level nest followed by a rejected IF and an unwind shows the LIFO order and that overflow does not corrupt the store. A long pseudo-random legal sequence, with the mask and store modelled arithmetically, covers mixed nesting. Separate runs after reset cover underflow and the sticky error.

// File: rtl/divmask_pkg.sv
package divmask_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_IF    = 2'd1,
        OP_ELSE  = 2'd2,
        OP_ENDIF = 2'd3
    } br_op_e;

    typedef enum logic [1:0] {
        NEST_EMPTY   = 2'd0,
        NEST_PARTIAL = 2'd1,
        NEST_FULL    = 2'd2
    } nest_state_e;
endpackage

// File: rtl/divmask_rules.sv
module divmask_rules
    import divmask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  br_op_e           op,
    input  logic             nest_empty,
    input  logic             nest_full,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond_mask,
    input  logic [LANES-1:0] saved_mask,
    output logic [LANES-1:0] next_mask,
    output logic             do_push,
    output logic             do_pop,
    output logic             fault,
    output logic             next_skip
);
    logic [LANES-1:0] narrowed;
    logic [LANES-1:0] flipped;

    assign narrowed = cond_mask & cur_mask;
    assign flipped  = saved_mask & ~cur_mask;

    always_comb begin
        next_mask = cur_mask;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        fault     = 1'b0;
        next_skip = 1'b0;
        unique case (op)
            OP_IF: begin
                if (nest_full) begin
                    fault = 1'b1;
                end else begin
                    do_push   = 1'b1;
                    next_mask = narrowed;
                    next_skip = ~|narrowed;
                end
            end
            OP_ELSE: begin
                if (nest_empty) begin
                    fault = 1'b1;
                end else begin
                    next_mask = flipped;
                    next_skip = ~|flipped;
                end
            end
            OP_ENDIF: begin
                if (nest_empty) begin
                    fault = 1'b1;
                end else begin
                    do_pop    = 1'b1;
                    next_mask = saved_mask;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/divmask_stack.sv
module divmask_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PW-1:0]    level,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] top
);
    logic [LANES-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (push && level == PW'(g)) begin
                entry[g] <= din;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == PW'(i + 1)) begin
                top = entry[i];
            end
        end
    end
endmodule

// File: rtl/divmask_ctrl.sv
module divmask_ctrl
    import divmask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic [LANES-1:0] cmp_mask,
    output logic [LANES-1:0] exec_mask,
    output logic             skip,
    output logic             err
);
    localparam int PW = $clog2(DEPTH + 1);

    nest_state_e      state_q, state_d;
    logic [PW-1:0]    lvl_q, lvl_d;
    logic [LANES-1:0] exec_q;
    logic             skip_q, err_q;

    logic [LANES-1:0] saved_mask, next_mask;
    logic             do_push, do_pop, fault, next_skip;
    logic             nest_empty, nest_full;

    assign nest_empty = (state_q == NEST_EMPTY);
    assign nest_full  = (state_q == NEST_FULL);

    divmask_rules #(.LANES(LANES)) u_rules (
        .op         (br_op_e'(op)),
        .nest_empty (nest_empty),
        .nest_full  (nest_full),
        .cur_mask   (exec_q),
        .cond_mask  (cmp_mask),
        .saved_mask (saved_mask),
        .next_mask  (next_mask),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .fault      (fault),
        .next_skip  (next_skip)
    );

    divmask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PW(PW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .level (lvl_q),
        .din   (exec_q),
        .top   (saved_mask)
    );

    // Nesting-level transitions
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            NEST_EMPTY: begin
                if (do_push) begin
                    lvl_d   = lvl_q + 1'b1;
                    state_d = (DEPTH == 1) ? NEST_FULL : NEST_PARTIAL;
                end
            end
            NEST_PARTIAL: begin
                if (do_push) begin
                    lvl_d = lvl_q + 1'b1;
                    if (lvl_q == PW'(DEPTH - 1)) state_d = NEST_FULL;
                end else if (do_pop) begin
                    lvl_d = lvl_q - 1'b1;
                    if (lvl_q == PW'(1)) state_d = NEST_EMPTY;
                end
            end
            NEST_FULL: begin
                if (do_pop) begin
                    lvl_d   = lvl_q - 1'b1;
                    state_d = (DEPTH == 1) ? NEST_EMPTY : NEST_PARTIAL;
                end
            end
            default: begin
                state_d = NEST_EMPTY;
                lvl_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NEST_EMPTY;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= '1;
            skip_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            exec_q <= next_mask;
            skip_q <= next_skip;
            err_q  <= err_q | fault;
        end
    end

    assign exec_mask = exec_q;
    assign skip      = skip_q;
    assign err       = err_q;
endmodule

// File: rtl/divmask_chk.sv
module divmask_chk #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    parameter int PW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op,
    input logic [LANES-1:0] cmp,
    input logic [LANES-1:0] exec,
    input logic             skip,
    input logic             err,
    input logic [PW-1:0]    lvl
);
    assert_if_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && lvl != PW'(DEPTH)) |=> exec == ($past(cmp) & $past(exec)));

    assert_if_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && lvl != PW'(DEPTH)) |=> skip == (exec == '0));

    assert_else_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2 && lvl != '0) |=> skip == (exec == '0));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0) |=> ($stable(exec) && !skip));

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= PW'(DEPTH));

    assert_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && lvl == PW'(DEPTH)) |=> ($stable(exec) && $stable(lvl) && err));

    assert_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1] && lvl == '0) |=> ($stable(exec) && $stable(lvl) && err));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind divmask_ctrl divmask_chk #(.LANES(LANES), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .cmp   (cmp_mask),
    .exec  (exec_mask),
    .skip  (skip),
    .err   (err),
    .lvl   (lvl_q)
);

// File: tb/divmask_ctrl_test.sv
module divmask_ctrl_test;
    localparam int L = 64;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [L-1:0] cmp_mask = '0;
    logic [L-1:0] exec_mask;
    logic         skip, err;

    int errors = 0;
    int checks = 0;

    // Reference model state
    logic [L-1:0] m_exec;
    logic [L-1:0] m_stk [D];
    int           m_lvl;
    logic         m_skip, m_err;
    logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    divmask_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op(op), .cmp_mask(cmp_mask),
        .exec_mask(exec_mask), .skip(skip), .err(err)
    );

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [63:0] next_rng(logic [63:0] s);
        logic [63:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic compare(string tag);
        checks++;
        if (exec_mask !== m_exec) begin
            errors++;
            $display("FAIL %s exec actual=%h expected=%h", tag, exec_mask, m_exec);
        end
        checks++;
        if (skip !== m_skip) begin
            errors++;
            $display("FAIL %s skip actual=%b expected=%b", tag, skip, m_skip);
        end
        checks++;
        if (err !== m_err) begin
            errors++;
            $display("FAIL %s err actual=%b expected=%b", tag, err, m_err);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_exec = '1;
        m_lvl = 0;
        m_skip = 1'b0;
        m_err = 1'b0;
        compare("R1");
    endtask

    // Apply one operation at a falling edge; check at the next falling edge.
    task automatic step(logic [1:0] o, logic [L-1:0] c);
        string tag;
        op = o;
        cmp_mask = c;
        @(negedge clk);
        m_skip = 1'b0;
        unique case (o)
            2'd1: begin
                if (m_lvl == D) begin
                    m_err = 1'b1;
                    tag = "R9";
                end else begin
                    m_stk[m_lvl] = m_exec;
                    m_lvl++;
                    m_exec = c & m_exec;
                    m_skip = (m_exec == '0);
                    tag = m_skip ? "R3" : "R2";
                end
            end
            2'd2: begin
                if (m_lvl == 0) begin
                    m_err = 1'b1;
                    tag = "R10";
                end else begin
                    m_exec = m_stk[m_lvl-1] & ~m_exec;
                    m_skip = (m_exec == '0);
                    tag = m_skip ? "R5" : "R4";
                end
            end
            2'd3: begin
                if (m_lvl == 0) begin
                    m_err = 1'b1;
                    tag = "R10";
                end else begin
                    m_lvl--;
                    m_exec = m_stk[m_lvl];
                    tag = "R6";
                end
            end
            default: tag = "R7";
        endcase
        if (m_err && o == 2'd0) tag = "R11";
        compare(tag);
        op = 2'd0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // Directed IF / ELSE / ENDIF patterns
        step(2'd0, '1);
        step(2'd1, {32{2'b10}});
        step(2'd2, '0);
        step(2'd3, '0);
        step(2'd1, '1);
        step(2'd1, '0);
        step(2'd2, '0);
        step(2'd3, '0);
        step(2'd3, '0);
        step(2'd1, 64'h8000_0000_0000_0001);
        step(2'd1, 64'h0000_0000_0000_0001);
        step(2'd2, '0);
        step(2'd3, '0);
        step(2'd3, '0);
        step(2'd0, 64'h1234);

        // R8 / R9: full nest, rejected IF, unwind in reverse order
        for (int i = 0; i < D; i++) begin
            step(2'd1, ~(64'h1 << (i * 7)));
        end
        step(2'd1, '0);
        for (int i = 0; i < D; i++) begin
            step(2'd3, '0);
        end
        step(2'd0, '0);

        // Long legal pseudo-random sequence
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]   o;
            logic [L-1:0] c;
            rng = next_rng(rng);
            o = rng[1:0];
            if (o == 2'd1 && m_lvl == D) o = 2'd3;
            if (o[1] && m_lvl == 0) o = 2'd1;
            unique case (rng[3:2])
                2'd0: c = '1;
                2'd1: c = '0;
                2'd2: c = next_rng(rng);
                default: c = next_rng(rng) & next_rng(~rng);
            endcase
            step(o, c);
        end

        // R10 / R11: underflow on ELSE and ENDIF, sticky error
        do_reset();
        step(2'd2, '0);
        step(2'd0, '0);
        step(2'd1, 64'hF0);
        step(2'd3, '0);
        do_reset();
        step(2'd3, '1);
        step(2'd0, '1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule